// File: doc/BRIEF.md
# Parallel Converter Bus Sequencer

This block sits on the host side of a byte-wide parallel bus and runs one conversion transaction on a 10-bit multichannel converter each time it is started. It presents a control byte on the bus under chip select and a write strobe. It then waits for the converter's active-low completion interrupt. Finally it reads the 10-bit result in two passes with the read strobe held low. In the first pass the high-byte select is low and bus bits 7..0 are result bits 7..0. In the second pass the select is high and bus bits 1..0 are result bits 9..8.

Every setup time, strobe width and access time is counted in system-clock cycles and set by a parameter. The user picks the counts from the system clock period so that each minimum time on the converter side is met. The assembled result comes out with a one-cycle valid pulse.

The interrupt is ignored for a set number of cycles after the write, because any bus access wakes the converter from power-down. A watchdog then limits how long the block waits. If no interrupt arrives in that time, the block abandons the transaction and raises a sticky timeout flag.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, cs_n, wr_n and rd_n are 1 and hben, bus_oe, busy, result_valid and timeout_flag are 0.
- R2: When a start is accepted, the next cycle begins the write phase, which lasts CS_SETUP+WR_WIDTH+1 cycles with cs_n low. wr_n goes low for exactly WR_WIDTH cycles, starting CS_SETUP cycles into the phase. bus_oe is 1 and bus_out carries the control byte latched at start for the first CS_SETUP+WR_WIDTH cycles. bus_oe drops in the same cycle that wr_n returns high.
- R3: start is ignored while busy is 1. No second write occurs, and the control byte captured by the converter is the one latched at the accepted start.
- R4: In the wait phase, int_n is ignored during the first WAKE_CYCLES cycles. An int_n that is already low at that point starts the read in the cycle right after the window ends.
- R5: The read starts the cycle after int_n is seen low and keeps cs_n and rd_n low throughout. It spends RD_ACCESS cycles with hben 0, sampling bus_in[7:0] in the last of them as result bits 7..0. It then spends HB_ACCESS cycles with hben 1, sampling bus_in[1:0] in the last of them as result bits 9..8.
- R6: In the cycle after the read, result_valid is 1 for exactly one cycle and result holds the assembled value. result changes only in such a cycle and otherwise holds its value.
- R7: If int_n is not seen low by wait cycle WAKE_CYCLES+WDOG_CYCLES-1, the block returns to idle with no read and sets timeout_flag. An int_n low in exactly that last cycle still wins and starts a read. timeout_flag stays 1 until the next accepted start clears it.
- R8: bus_oe is 1 only in the write phase and never while rd_n is 0.
- R9: After each return to idle, a start is accepted only once cs_n has been high for CS_GAP cycles. An earlier start pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one transaction |
| ctrl_byte | input | 8 | Control byte to write, latched at start |
| result | output | 10 | Last assembled conversion result |
| result_valid | output | 1 | One-cycle pulse when result is new |
| busy | output | 1 | Transaction in progress |
| timeout_flag | output | 1 | Sticky: last wait ended without interrupt |
| cs_n | output | 1 | Chip select to converter, active low |
| wr_n | output | 1 | Write strobe, control byte taken on its rise |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | High-byte select during reads |
| bus_out | output | 8 | Data driven onto the shared bus |
| bus_oe | output | 1 | Output enable for bus_out |
| bus_in | input | 8 | Data sampled from the shared bus |
| int_n | input | 1 | Converter completion interrupt, active low |

## Verification
The watchdog expiry and the arrival of the interrupt can fall in the same cycle. The bench drives int_n low in exactly the last wait cycle and expects a read with no timeout. It also drives int_n one cycle later and expects a timeout with no read. The bench also raises start while a transaction is running, and one cycle before the idle gap ends. Each outcome is judged by comparing the strobe pins with a cycle-by-cycle expectation and by checking which byte the converter model captured.

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int CS_SETUP    = 12,
  parameter int WR_WIDTH    = 12,
  parameter int WAKE_CYCLES = 8,
  parameter int WDOG_CYCLES = 2000,
  parameter int RD_ACCESS   = 11,
  parameter int HB_ACCESS   = 11,
  parameter int CS_GAP      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] ctrl_byte,
  output logic [9:0] result,
  output logic       result_valid,
  output logic       busy,
  output logic       timeout_flag,
  output logic       cs_n,
  output logic       wr_n,
  output logic       rd_n,
  output logic       hben,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  input  logic [7:0] bus_in,
  input  logic       int_n
);

  localparam int WR_LAST   = CS_SETUP + WR_WIDTH;
  localparam int WAIT_LAST = WAKE_CYCLES + WDOG_CYCLES - 1;
  localparam int RD_LAST   = RD_ACCESS - 1;
  localparam int HB_LAST   = HB_ACCESS - 1;
  localparam int M1        = (WR_LAST > WAIT_LAST) ? WR_LAST : WAIT_LAST;
  localparam int M2        = (RD_ACCESS > HB_ACCESS) ? RD_ACCESS : HB_ACCESS;
  localparam int M3        = (M1 > M2) ? M1 : M2;
  localparam int CNT_MAX   = (M3 > CS_GAP) ? M3 : CS_GAP;
  localparam int CNT_W     = $clog2(CNT_MAX + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_WAIT, S_RDLO, S_RDHI, S_DONE
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctrl_q;
  logic [7:0]       lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      ctrl_q       <= '0;
      lo_q         <= '0;
      result       <= '0;
      timeout_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start && cnt == CNT_W'(CS_GAP)) begin
            st           <= S_WRITE;
            cnt          <= '0;
            ctrl_q       <= ctrl_byte;
            timeout_flag <= 1'b0;
          end else if (cnt != CNT_W'(CS_GAP)) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRITE: begin
          if (cnt == CNT_W'(WR_LAST)) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt >= CNT_W'(WAKE_CYCLES) && !int_n) begin
            st  <= S_RDLO;
            cnt <= '0;
          end else if (cnt == CNT_W'(WAIT_LAST)) begin
            st           <= S_IDLE;
            cnt          <= '0;
            timeout_flag <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RDLO: begin
          if (cnt == CNT_W'(RD_LAST)) begin
            lo_q <= bus_in;
            st   <= S_RDHI;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RDHI: begin
          if (cnt == CNT_W'(HB_LAST)) begin
            result <= {bus_in[1:0], lo_q};
            st     <= S_DONE;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DONE: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
        default: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign cs_n         = !(st == S_WRITE || st == S_RDLO || st == S_RDHI);
  assign wr_n         = !(st == S_WRITE && cnt >= CNT_W'(CS_SETUP) && cnt < CNT_W'(WR_LAST));
  assign bus_oe       = (st == S_WRITE) && (cnt < CNT_W'(WR_LAST));
  assign bus_out      = ctrl_q;
  assign rd_n         = !(st == S_RDLO || st == S_RDHI);
  assign hben         = (st == S_RDHI);
  assign busy         = (st != S_IDLE);
  assign result_valid = (st == S_DONE);

  AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!cs_n && bus_oe)); // R2
  AST_HBEN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    hben |-> (!rd_n && !cs_n)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_valid); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !start) |=> timeout_flag); // R7
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe); // R8
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n && wr_n && !bus_oe) |=> wr_n); // R3

endmodule

// File: tb/adc_bus_ctrl_tb.sv
`timescale 1ns/1ps
module adc_bus_ctrl_tb_top;
  localparam int S    = 12;
  localparam int W    = 12;
  localparam int WAKE = 8;
  localparam int WDOG = 300;
  localparam int RD   = 11;
  localparam int HB   = 11;
  localparam int GAP  = 4;
  localparam int LAST = WAKE + WDOG - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic [9:0] result;
  logic       result_valid, busy, timeout_flag;
  logic       cs_n, wr_n, rd_n, hben, bus_oe;
  logic [7:0] bus_out;
  logic [7:0] bus_in;
  logic       int_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_bus_ctrl #(
    .CS_SETUP(S), .WR_WIDTH(W), .WAKE_CYCLES(WAKE), .WDOG_CYCLES(WDOG),
    .RD_ACCESS(RD), .HB_ACCESS(HB), .CS_GAP(GAP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_byte(ctrl_byte),
    .result(result), .result_valid(result_valid), .busy(busy),
    .timeout_flag(timeout_flag), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .hben(hben), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .int_n(int_n)
  );

  // converter bus model: data valid only after 10 cycles (50 ns) of access
  logic [9:0] conv_res = 10'h000;
  logic [7:0] cap = 8'h00;
  int rd_seen = 0;
  int hb_seen = 0;

  always @(posedge clk) begin
    rd_seen <= (!rd_n && !cs_n) ? rd_seen + 1 : 0;
    hb_seen <= hben ? hb_seen + 1 : 0;
    if (!wr_n && bus_oe && !cs_n) cap <= bus_out;
  end

  always_comb begin
    if (!cs_n && !rd_n) begin
      if (hben) bus_in = (hb_seen >= 10) ? {6'b0, conv_res[9:8]} : 8'hA5;
      else      bus_in = (rd_seen >= 10) ? conv_res[7:0] : 8'h5A;
    end else begin
      bus_in = 8'h00;
    end
  end

  function automatic logic [5:0] pins();
    return {cs_n, wr_n, rd_n, hben, bus_oe, busy};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge where a start will be accepted
  task automatic run_txn(input logic [7:0] ctrl, input logic [9:0] res,
                         input int int_at, input bit poke);
    int accept;
    bit do_read;
    conv_res  = res;
    start     = 1'b1;
    ctrl_byte = ctrl;
    @(negedge clk);
    start     = 1'b0;
    ctrl_byte = 8'h00;
    chk("R7 flag cleared by start", timeout_flag, 0);
    for (int t = 0; t <= S + W; t++) begin
      chk("R2 write pins", pins(),
          {1'b0, !(t >= S && t < S + W), 1'b1, 1'b0, (t < S + W), 1'b1});
      if (t < S + W) chk("R2 write data", bus_out, ctrl);
      if (t == S + W) chk("R2 captured byte", cap, ctrl);
      @(negedge clk);
    end
    accept  = (int_at < WAKE) ? WAKE : int_at;
    do_read = (accept <= LAST);
    for (int u = 0; ; u++) begin
      if (u >= int_at) int_n = 1'b0;
      if (poke) start = (u == 1);
      if (poke && u == 1) ctrl_byte = 8'hFF;
      chk("R4 wait pins", pins(), 6'b111001);
      @(negedge clk);
      if (do_read && u == accept) break;
      if (!do_read && u == LAST) break;
    end
    start = 1'b0;
    ctrl_byte = 8'h00;
    if (do_read) begin
      for (int r = 0; r < RD; r++) begin
        if (r == 2) int_n = 1'b1;
        chk("R5 low read pins", pins(), 6'b010001);
        @(negedge clk);
      end
      for (int h = 0; h < HB; h++) begin
        chk("R5 high read pins", pins(), 6'b010101);
        @(negedge clk);
      end
      chk("R6 valid", result_valid, 1);
      chk("R5 result", result, res);
      chk("R8 pins at done", pins(), 6'b111001);
      @(negedge clk);
      chk("R6 valid single", result_valid, 0);
      chk("R6 result held", result, res);
      chk("R3 idle pins", pins(), 6'b111000);
      chk("R3 captured byte kept", cap, ctrl);
      chk("R7 no timeout", timeout_flag, 0);
    end else begin
      int_n = 1'b1;
      chk("R7 timeout flag", timeout_flag, 1);
      chk("R7 idle pins", pins(), 6'b111000);
      chk("R7 no valid", result_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins", pins(), 6'b111000);
    chk("R1 reset valid", result_valid, 0);
    chk("R1 reset flag", timeout_flag, 0);
    rst_n = 1'b1;
    chk("R1 first idle", pins(), 6'b111000);
    repeat (GAP) @(negedge clk);

    run_txn(8'h8F, 10'h2C3, 20, 1'b0);
    repeat (GAP) @(negedge clk);
    run_txn(8'h31, 10'h000, 0, 1'b0);            // R4 early interrupt
    repeat (GAP) @(negedge clk);
    run_txn(8'h4C, 10'h3FF, LAST, 1'b0);         // R7 interrupt on last cycle wins
    repeat (GAP) @(negedge clk);
    run_txn(8'h22, 10'h1B6, LAST + 1, 1'b0);     // R7 timeout
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R7 flag sticky", timeout_flag, 1);
      chk("R7 idle pins", pins(), 6'b111000);
    end
    run_txn(8'h96, 10'h254, 15, 1'b1);           // R3 start poked while busy
    for (int k = 0; k < GAP + 3; k++) begin
      @(negedge clk);
      chk("R3 no extra txn", pins(), 6'b111000);
    end
    run_txn(8'h5D, 10'h18E, 9, 1'b0);
    repeat (GAP - 1) @(negedge clk);
    start = 1'b1;                                // R9 one cycle too early
    ctrl_byte = 8'hEE;
    @(negedge clk);
    start = 1'b0;
    chk("R9 early start dropped", pins(), 6'b111000);
    run_txn(8'h07, 10'h2A1, 12, 1'b0);           // R9 accepted at gap boundary
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule